// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port with Per-Pin Open-Drain Selection

This block is one eight-bit general-purpose I/O port on a simple synchronous register bus. Software programs three read/write registers: a direction register, an output data register and an open-drain select register. A fourth address returns the port level. For each bit, that value is the output data bit when the pin is an output, or the synchronised pin level when the pin is an input. The block drives an output-enable and an output value per pin toward external tri-state pads, and it takes the pad input levels back in.

Each pin configured as an output works in one of two modes. In push-pull mode the pin always drives. In open-drain mode the pin only pulls low and floats when its data bit is 1.

Two kinds of reset are handled. A full reset, either power-on or hardware standby, clears all three registers. A retaining reset, either manual reset or software standby, keeps them and blocks bus writes while it is active.

Top module: `gpio_od_port`

## Requirements
- R1: After power-on reset (`rstFullN` low), the direction, data and open-drain registers read 8'h00 and every `padOe` bit is 0.
- R2: A bus write with `busWe` high stores `busWdata` in the direction register at address 0, the data register at address 1 or the open-drain register at address 2. A read at the same address returns the stored value.
- R3: Address 3 is the read-only port register. A write to it leaves all three registers unchanged.
- R4: For a bit whose direction bit is 1, a read of address 3 returns that bit of the data register.
- R5: For a bit whose direction bit is 0, a read of address 3 returns the pin level. A change on `pinIn` first shows in the read value after the second rising clock edge.
- R6: An output pin (direction 1) with open-drain bit 0 has `padOe` = 1 and `padOut` equal to its data bit.
- R7: An output pin with open-drain bit 1 has `padOe` = 1 and `padOut` = 0 when its data bit is 0. It has `padOe` = 0 when its data bit is 1.
- R8: An input pin (direction 0) always has `padOe` = 0.
- R9: While `hwStandby` is high, all three registers are cleared to 8'h00 at each clock, and bus writes have no effect.
- R10: While `rstKeepN` is low (manual reset), all three registers keep their values and bus writes have no effect.
- R11: While `swStandby` is high, all three registers keep their values and bus writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstFullN | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| hwStandby | input | 1 | Hardware standby; clears the registers while high |
| rstKeepN | input | 1 | Manual reset, active low; registers retained, writes blocked |
| swStandby | input | 1 | Software standby; registers retained, writes blocked |
| busAddr | input | 2 | Register address: 0 direction, 1 data, 2 open-drain, 3 port |
| busWe | input | 1 | Write enable for the addressed register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data of the addressed register |
| pinIn | input | 8 | Pad input levels, asynchronous |
| padOe | output | 8 | Per-pin output enable to the pad |
| padOut | output | 8 | Per-pin value driven when enabled |

## Verification
The assertions assume that `pinIn` is the only asynchronous input. Every bus and standby input is assumed to change away from the rising clock edge, so a write strobe is seen for exactly the cycles `busWe` is held. The pin-lag property assumes `pinIn` holds each value for at least one clock. The stimulus drives every input on the falling edge and holds each pin pattern for several clocks, which keeps it within these assumptions. The retention checks assert both retaining resets and hardware standby alone and in turn, never together with a full reset.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_OD   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic              wrDir;
    logic              wrData;
    logic              wrOd;
    logic              clearAll;
    logic [ADDR_W-1:0] rdSel;
  } gpio_strobe_t;
endpackage

// File: rtl/gpio_od_ctrl.sv
module gpio_od_ctrl
  import gpio_od_pkg::*;
(
  input  logic              clk,
  input  logic              rstFullN,
  input  logic              hwStandby,
  input  logic              rstKeepN,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output gpio_strobe_t      stb
);
  logic writeOk;

  // Writes pass only when no reset or standby class is active
  assign writeOk = busWe && rstKeepN && !swStandby && !hwStandby;

  always_comb begin
    stb          = '0;
    stb.clearAll = hwStandby;
    stb.rdSel    = busAddr;
    if (writeOk) begin
      unique case (busAddr)
        ADDR_DIR:  stb.wrDir  = 1'b1;
        ADDR_DATA: stb.wrData = 1'b1;
        ADDR_OD:   stb.wrOd   = 1'b1;
        default:   ;  // port register is read-only
      endcase
    end
  end

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstFullN)
    $onehot0({stb.wrDir, stb.wrData, stb.wrOd}));
  p_no_port_write_r3: assert property (@(posedge clk) disable iff (!rstFullN)
    (busAddr == ADDR_PORT) |-> !(stb.wrDir || stb.wrData || stb.wrOd));
  p_keep_blocks_r10: assert property (@(posedge clk) disable iff (!rstFullN)
    (!rstKeepN || swStandby) |-> !(stb.wrDir || stb.wrData || stb.wrOd));
endmodule

// File: rtl/gpio_od_datapath.sv
module gpio_od_datapath
  import gpio_od_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstFullN,
  input  gpio_strobe_t     stb,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dirReg, dataReg, odReg;
  logic [WIDTH-1:0] syncStg [SYNC_STAGES];
  logic [WIDTH-1:0] pinSync, portView;

  // Register bank: full clear has priority over writes
  always_ff @(posedge clk or negedge rstFullN) begin
    if (!rstFullN) begin
      dirReg  <= '0;
      dataReg <= '0;
      odReg   <= '0;
    end else if (stb.clearAll) begin
      dirReg  <= '0;
      dataReg <= '0;
      odReg   <= '0;
    end else begin
      if (stb.wrDir)  dirReg  <= busWdata;
      if (stb.wrData) dataReg <= busWdata;
      if (stb.wrOd)   odReg   <= busWdata;
    end
  end

  // Pin synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstFullN) begin
        if (!rstFullN) syncStg[s] <= '0;
        else if (s == 0) syncStg[s] <= pinIn;
        else syncStg[s] <= syncStg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign pinSync = syncStg[LAST];

  // Per-bit readback select and pad drive
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign portView[b] = dirReg[b] ? dataReg[b] : pinSync[b];
      assign padOe[b]    = dirReg[b] && !(odReg[b] && dataReg[b]);
      assign padOut[b]   = dataReg[b];
    end
  endgenerate

  always_comb begin
    unique case (stb.rdSel)
      ADDR_DIR:  busRdata = dirReg;
      ADDR_DATA: busRdata = dataReg;
      ADDR_OD:   busRdata = odReg;
      default:   busRdata = portView;
    endcase
  end

  // Checks on register and pad behaviour
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstFullN)
    stb.clearAll |=> (dirReg == '0 && dataReg == '0 && odReg == '0));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstFullN)
    !(stb.wrDir || stb.wrData || stb.wrOd || stb.clearAll)
      |=> ($stable(dirReg) && $stable(dataReg) && $stable(odReg)));
  p_od_low_only_r7: assert property (@(posedge clk) disable iff (!rstFullN)
    (odReg & padOe & padOut) == '0);
  p_input_off_r8: assert property (@(posedge clk) disable iff (!rstFullN)
    (padOe & ~dirReg) == '0);

  generate
    if (SYNC_STAGES == 2) begin : g_lagchk
      logic [1:0] upCnt;
      always_ff @(posedge clk or negedge rstFullN) begin
        if (!rstFullN) upCnt <= '0;
        else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
      end
      p_pin_lag_r5: assert property (@(posedge clk) disable iff (!rstFullN)
        (upCnt >= 2'd2) |-> (((portView ^ $past(pinIn, 2)) & ~dirReg) == '0));
    end
  endgenerate
endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port
  import gpio_od_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstFullN,
  input  logic              hwStandby,
  input  logic              rstKeepN,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut
);
  gpio_strobe_t stb;

  gpio_od_ctrl ctrl_i (
    .clk(clk), .rstFullN(rstFullN), .hwStandby(hwStandby),
    .rstKeepN(rstKeepN), .swStandby(swStandby),
    .busAddr(busAddr), .busWe(busWe), .stb(stb)
  );

  gpio_od_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstFullN(rstFullN), .stb(stb), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .padOe(padOe), .padOut(padOut)
  );
endmodule

// File: tb/gpio_od_port_tb_top.sv
module gpio_od_port_tb_top;
  logic       clk = 1'b0;
  logic       rstFullN = 1'b0, hwStandby = 1'b0, rstKeepN = 1'b1, swStandby = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0, busRdata, pinIn = '0, padOe, padOut;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_od_port dut_i (.*);

  // {dir, data, od, pin, expOe, expOut, expPort}
  localparam logic [55:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'hFF, 8'hA5, 8'hA5},
    {8'hFF, 8'hA5, 8'hFF, 8'h00, 8'h5A, 8'hA5, 8'hA5},
    {8'h00, 8'h3C, 8'h00, 8'h96, 8'h00, 8'h3C, 8'h96},
    {8'hF0, 8'h5A, 8'h30, 8'hC3, 8'hE0, 8'h5A, 8'h53},
    {8'h0F, 8'hFF, 8'h0F, 8'h81, 8'h00, 8'hFF, 8'h8F},
    {8'hAA, 8'h00, 8'hAA, 8'h55, 8'hAA, 8'h00, 8'h55}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic chkRegs(input string req, input logic [7:0] d0, d1, d2);
    logic [7:0] v;
    rd(2'd0, v); chk(req, v, d0);
    rd(2'd1, v); chk(req, v, d1);
    rd(2'd2, v); chk(req, v, d2);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chkRegs("R1", 8'h00, 8'h00, 8'h00);
    chk("R1 oe", padOe, 8'h00);
    rstFullN = 1'b1;
    @(negedge clk);

    // R2 write and read back
    wr(2'd0, 8'h12); wr(2'd1, 8'h34); wr(2'd2, 8'h56);
    chkRegs("R2", 8'h12, 8'h34, 8'h56);

    // R3 port register ignores writes
    wr(2'd3, 8'hFF);
    chkRegs("R3", 8'h12, 8'h34, 8'h56);

    // Vector table: R4 R5 R6 R7 R8
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, VEC[i][55:48]); wr(2'd1, VEC[i][47:40]); wr(2'd2, VEC[i][39:32]);
      pinIn = VEC[i][31:24];
      repeat (3) @(negedge clk);
      chk("R6/R7/R8 oe", padOe, VEC[i][23:16]);
      chk("R6 out", padOut, VEC[i][15:8]);
      rd(2'd3, v); chk("R4/R5 port", v, VEC[i][7:0]);
    end

    // R5 two-clock lag
    wr(2'd0, 8'h00);
    pinIn = 8'h00; repeat (3) @(negedge clk);
    pinIn = 8'hFF;
    @(negedge clk); rd(2'd3, v); chk("R5 lag1", v, 8'h00);
    @(negedge clk); rd(2'd3, v); chk("R5 lag2", v, 8'hFF);

    // R10 manual reset retains and blocks writes
    wr(2'd0, 8'hC3); wr(2'd1, 8'h69); wr(2'd2, 8'h0F);
    @(negedge clk); rstKeepN = 1'b0;
    wr(2'd0, 8'h00); wr(2'd1, 8'hFF);
    chkRegs("R10", 8'hC3, 8'h69, 8'h0F);
    rstKeepN = 1'b1;

    // R11 software standby retains and blocks writes
    @(negedge clk); swStandby = 1'b1;
    wr(2'd2, 8'hF0); wr(2'd1, 8'h00);
    chkRegs("R11", 8'hC3, 8'h69, 8'h0F);
    swStandby = 1'b0;

    // R9 hardware standby clears, writes ignored
    @(negedge clk); hwStandby = 1'b1;
    wr(2'd0, 8'hFF);
    chkRegs("R9", 8'h00, 8'h00, 8'h00);
    chk("R9 oe", padOe, 8'h00);
    hwStandby = 1'b0;
    wr(2'd0, 8'h81);
    rd(2'd0, v); chk("R9 release", v, 8'h81);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end
endmodule